// File: doc/BRIEF.md
# Oversampling Accumulate-and-Dump Decimator

This block sits behind an analog-to-digital converter's sample strobe. It adds up a programmable power-of-two number of consecutive conversion results. When a group is complete it scales the total down by a programmable right shift, rounding to the nearest value. It delivers one 16-bit result per group, so the output rate is lower than the input rate by the group length. The timing of each conversion does not change: the block counts accepted sample strobes and does nothing else.

A 3-bit ratio code selects the group length. A 4-bit shift code selects the scaling. When the oversampling enable is low, the block is a pass-through: each sample appears zero-extended at the output. Any change of either code, and any cycle with the enable low, throws away the partial group, so the next result always covers a complete, fresh group.

Top module: `osr_decimator`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `res_vld` is 0 and `res_data` is 0.
- R2: With `os_en` high, ratio code k (0..7) gives a group length of N = 2^(k+1) samples, from 2 up to 256. Exactly one result is produced for every N accepted samples (`smp_vld` high).
- R3: A shift code of 0..8 gives a right shift of M equal to that code. Codes 9 to 15 act as a shift of 8.
- R4: Each result is floor((S + 2^(M-1)) / 2^M), where S is the exact sum of the group's samples. When M = 0 the result is S unchanged.
- R5: Only the low 16 bits of the rounded, shifted value appear on `res_data`. The sum is held exactly, with no overflow, for up to 256 samples of 4095.
- R6: `res_vld` is high for one clock, in the cycle after the clock edge that accepts the group's last sample. `res_data` keeps its value in every cycle in which `res_vld` is low.
- R7: In the cycle that completes a group, the accumulator restarts from zero. A sample accepted in the very next cycle counts as the first sample of the next group, so no sample is lost, even when samples arrive every cycle.
- R8: A change of `ratio_code` or `shift_code`, or a cycle with `os_en` low, discards the partial sum and the sample count. A sample accepted in the cycle of a code change becomes the first sample of the new group.
- R9: With `os_en` low, each accepted sample appears on `res_data` one cycle later, zero-extended to 16 bits, with `res_vld` high for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| os_en | input | 1 | 1 = accumulate and decimate, 0 = pass each sample through |
| ratio_code | input | 3 | Group length code, N = 2^(code+1) |
| shift_code | input | 4 | Right-shift amount, saturating at 8 |
| smp_vld | input | 1 | The sample on `smp_data` is valid this cycle |
| smp_data | input | 12 | Unsigned conversion result |
| res_vld | output | 1 | One-cycle strobe: a new result is on `res_data` |
| res_data | output | 16 | Registered result, held between strobes |

## Verification
Every result is due exactly one clock edge after the edge that accepts the last sample of its group. In pass-through mode it is due one edge after the edge that accepts its sample.

The driver drives inputs on the falling edge. While it drives, it records the value of a rising-edge cycle counter plus one as the due cycle of any result it expects. The monitor samples on the falling edge and compares both the value and the cycle in which the strobe appears. A result that comes early, comes late or is not expected at all therefore fails.

Checks for the hold behaviour and the reset state are also taken on falling edges, after idle stretches with no samples.

// File: rtl/osr_pkg.sv
package osr_pkg;

    typedef enum logic {
        OSR_BYPASS = 1'b0,
        OSR_ACCUM  = 1'b1
    } osr_mode_e;

    // Samples per group for a given ratio code: 2^(code+1)
    function automatic int osr_group_len(input int code);
        return 1 << (code + 1);
    endfunction

endpackage

// File: rtl/osr_cfg_decode.sv
module osr_cfg_decode #(
    parameter int RATIO_CODE_W = 3,
    parameter int SHIFT_CODE_W = 4,
    parameter int MAX_SHIFT    = 8,
    parameter int CNT_W        = 2 ** RATIO_CODE_W,
    parameter int SH_W         = $clog2(MAX_SHIFT + 1)
) (
    input  logic [RATIO_CODE_W-1:0] ratio_code,
    input  logic [SHIFT_CODE_W-1:0] shift_code,
    output logic [CNT_W-1:0]        last_idx,
    output logic [SH_W-1:0]         shift_amt
);
    import osr_pkg::*;

    always_comb begin
        last_idx = CNT_W'(osr_group_len(int'(ratio_code)) - 1);
        if (int'(shift_code) > MAX_SHIFT) begin
            shift_amt = SH_W'(MAX_SHIFT);
        end else begin
            shift_amt = SH_W'(shift_code);
        end
    end

endmodule

// File: rtl/osr_round_shift.sv
module osr_round_shift #(
    parameter int ACC_W         = 20,
    parameter int SH_W          = 4,
    parameter int RES_W         = 16,
    parameter bit ROUND_NEAREST = 1'b1
) (
    input  logic [ACC_W-1:0] sum,
    input  logic [SH_W-1:0]  shamt,
    output logic [RES_W-1:0] res
);
    localparam int EXT_W = ACC_W + 1;

    logic [EXT_W-1:0] bias;
    logic [EXT_W-1:0] biased;
    logic [EXT_W-1:0] shifted;

    generate
        if (ROUND_NEAREST) begin : g_round
            always_comb begin
                if (shamt == '0) begin
                    bias = '0;
                end else begin
                    bias = EXT_W'(1) << (shamt - SH_W'(1));
                end
            end
        end else begin : g_trunc
            assign bias = '0;
        end
    endgenerate

    always_comb begin
        biased  = {1'b0, sum} + bias;
        shifted = biased >> shamt;
        res     = shifted[RES_W-1:0];
    end

endmodule

// File: rtl/osr_decimator.sv
module osr_decimator #(
    parameter int SMP_W        = 12,
    parameter int RES_W        = 16,
    parameter int RATIO_CODE_W = 3,
    parameter int SHIFT_CODE_W = 4,
    parameter int MAX_SHIFT    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    os_en,
    input  logic [RATIO_CODE_W-1:0] ratio_code,
    input  logic [SHIFT_CODE_W-1:0] shift_code,
    input  logic                    smp_vld,
    input  logic [SMP_W-1:0]        smp_data,
    output logic                    res_vld,
    output logic [RES_W-1:0]        res_data
);
    import osr_pkg::*;

    localparam int CNT_W = 2 ** RATIO_CODE_W;
    localparam int ACC_W = SMP_W + CNT_W;
    localparam int SH_W  = $clog2(MAX_SHIFT + 1);
    localparam logic [ACC_W:0] SMP_MAX = (ACC_W+1)'((1 << SMP_W) - 1);

    typedef struct packed {
        logic [ACC_W-1:0]        acc;
        logic [CNT_W-1:0]        cnt;
        logic [RATIO_CODE_W-1:0] ratio;
        logic [SHIFT_CODE_W-1:0] shift;
        logic [RES_W-1:0]        res;
        logic                    vld;
    } osr_state_t;

    osr_state_t state_d, state_q;

    osr_mode_e        mode;
    logic [CNT_W-1:0] last_idx;
    logic [SH_W-1:0]  shift_amt;
    logic             cfg_chg;
    logic [ACC_W-1:0] acc_base_d;
    logic [CNT_W-1:0] cnt_base_d;
    logic [ACC_W-1:0] acc_sum_d;
    logic [RES_W-1:0] scaled;

    osr_cfg_decode #(
        .RATIO_CODE_W (RATIO_CODE_W),
        .SHIFT_CODE_W (SHIFT_CODE_W),
        .MAX_SHIFT    (MAX_SHIFT),
        .CNT_W        (CNT_W),
        .SH_W         (SH_W)
    ) cfg_i (
        .ratio_code (ratio_code),
        .shift_code (shift_code),
        .last_idx   (last_idx),
        .shift_amt  (shift_amt)
    );

    osr_round_shift #(
        .ACC_W         (ACC_W),
        .SH_W          (SH_W),
        .RES_W         (RES_W),
        .ROUND_NEAREST (1'b1)
    ) rnd_i (
        .sum   (acc_sum_d),
        .shamt (shift_amt),
        .res   (scaled)
    );

    always_comb begin
        mode       = os_en ? OSR_ACCUM : OSR_BYPASS;
        cfg_chg    = (ratio_code != state_q.ratio) ||
                     (shift_code != state_q.shift) || !os_en;
        acc_base_d = cfg_chg ? '0 : state_q.acc;
        cnt_base_d = cfg_chg ? '0 : state_q.cnt;
        acc_sum_d  = acc_base_d + ACC_W'(smp_data);

        state_d       = state_q;
        state_d.vld   = 1'b0;
        state_d.ratio = ratio_code;
        state_d.shift = shift_code;
        state_d.acc   = acc_base_d;
        state_d.cnt   = cnt_base_d;

        if (mode == OSR_BYPASS) begin
            if (smp_vld) begin
                state_d.res = RES_W'(smp_data);
                state_d.vld = 1'b1;
            end
        end else if (smp_vld) begin
            if (cnt_base_d == last_idx) begin
                state_d.res = scaled;
                state_d.vld = 1'b1;
                state_d.acc = '0;
                state_d.cnt = '0;
            end else begin
                state_d.acc = acc_sum_d;
                state_d.cnt = cnt_base_d + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_vld  = state_q.vld;
    assign res_data = state_q.res;

    // R5: the partial sum never exceeds count * full-scale sample
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, state_q.acc} <= (ACC_W+1)'(state_q.cnt) * SMP_MAX);

    // R2: the count stays below the group length chosen by the ratio code
    assert_cnt_in_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |-> (state_q.cnt <= last_idx));

    // R8: a code change or a cycle with enable low restarts the group
    assert_cfg_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (state_q.cnt <= CNT_W'(1)));

    // R6: the result holds in every cycle without a strobe
    assert_res_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> $stable(res_data));

    // R9: pass-through delivers the zero-extended sample one cycle later
    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!os_en && smp_vld) |=> (res_vld && res_data == RES_W'($past(smp_data))));

endmodule

// File: tb/osr_decimator_tb_top.sv
module osr_decimator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        os_en = 1'b0;
    logic [2:0]  ratio_code = '0;
    logic [3:0]  shift_code = '0;
    logic        smp_vld = 1'b0;
    logic [11:0] smp_data = '0;
    logic        res_vld;
    logic [15:0] res_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [15:0] exp_val_q[$];
    int          exp_due_q[$];
    string       exp_req_q[$];
    logic [15:0] last_val = '0;

    int  n_m = 2;
    int  m_m = 0;
    int  acc_m = 0;
    int  cnt_m = 0;
    bit  en_m = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    osr_decimator dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_en      (os_en),
        .ratio_code (ratio_code),
        .shift_code (shift_code),
        .smp_vld    (smp_vld),
        .smp_data   (smp_data),
        .res_vld    (res_vld),
        .res_data   (res_data)
    );

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_exp(input logic [15:0] v, input string req);
        exp_val_q.push_back(v);
        exp_due_q.push_back(cyc + 1);
        exp_req_q.push_back(req);
    endtask

    // Inputs change on falling edges only
    task automatic set_cfg(input bit en, input logic [2:0] rc, input logic [3:0] sc);
        os_en = en;
        ratio_code = rc;
        shift_code = sc;
        smp_vld = 1'b0;
        en_m = en;
        n_m = 1 << (int'(rc) + 1);
        m_m = (int'(sc) > 8) ? 8 : int'(sc);
        acc_m = 0;
        cnt_m = 0;
        @(negedge clk);
    endtask

    task automatic send(input logic [11:0] s, input string req);
        int r;
        smp_vld = 1'b1;
        smp_data = s;
        if (!en_m) begin
            push_exp(16'(s), req);
        end else begin
            acc_m += int'(s);
            cnt_m++;
            if (cnt_m == n_m) begin
                r = acc_m + ((m_m > 0) ? (1 << (m_m - 1)) : 0);
                r = r >> m_m;
                push_exp(r[15:0], req);
                acc_m = 0;
                cnt_m = 0;
            end
        end
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares value and arrival cycle of every strobe
    always @(negedge clk) begin
        if (rst_n && !done && res_vld) begin
            if (exp_val_q.size() == 0) begin
                chk(1'b0, "R6 unexpected strobe", int'(res_data), -1);
            end else begin
                logic [15:0] ev;
                int ed;
                string er;
                ev = exp_val_q.pop_front();
                ed = exp_due_q.pop_front();
                er = exp_req_q.pop_front();
                chk(res_data == ev, er, int'(res_data), int'(ev));
                chk(cyc == ed, "R6 result timing", cyc, ed);
                last_val = ev;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(res_vld == 1'b0, "R1 vld in reset", int'(res_vld), 0);
        chk(res_data == 16'd0, "R1 data in reset", int'(res_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_vld == 1'b0, "R1 vld after reset", int'(res_vld), 0);
        chk(res_data == 16'd0, "R1 data after reset", int'(res_data), 0);

        // R4 and R7: N=2, M=1, back-to-back groups
        set_cfg(1'b1, 3'd0, 4'd1);
        send(12'd1, "R4 round up half");
        send(12'd2, "R4 round up half");
        send(12'd1, "R7 back-to-back group");
        send(12'd1, "R7 back-to-back group");
        send(12'd7, "R7 back-to-back group");
        send(12'd8, "R7 back-to-back group");
        idle(3);

        // R4: N=4, M=2
        set_cfg(1'b1, 3'd1, 4'd2);
        send(12'd1, "R4 half rounds up");
        send(12'd1, "R4 half rounds up");
        send(12'd0, "R4 half rounds up");
        send(12'd0, "R4 half rounds up");
        send(12'd1, "R4 below half rounds down");
        send(12'd0, "R4 below half rounds down");
        send(12'd0, "R4 below half rounds down");
        send(12'd0, "R4 below half rounds down");
        idle(3);

        // R3: shift code 12 acts as 8
        set_cfg(1'b1, 3'd3, 4'd12);
        for (int i = 0; i < 16; i++) send(12'hFFF, "R3 shift saturates at 8");
        idle(3);

        // R5: N=256, M=0, full scale keeps low 16 bits (65280)
        set_cfg(1'b1, 3'd7, 4'd0);
        for (int i = 0; i < 256; i++) send(12'hFFF, "R5 low 16 bits kept");
        idle(3);

        // R2: sweep every ratio code with varied data and gaps
        for (int k = 0; k < 8; k++) begin
            set_cfg(1'b1, 3'(k), 4'(k + 1));
            for (int i = 0; i < (2 << k); i++) begin
                send(12'((i * 37 + k * 101 + 5) & 12'hFFF), "R2 group length");
                if ((i % 3) == 2) idle(1);
            end
            idle(3);
        end

        // R8: a partial group dropped on a shift code change
        set_cfg(1'b1, 3'd2, 4'd0);
        for (int i = 0; i < 3; i++) send(12'd4000, "R8 partial dropped");
        set_cfg(1'b1, 3'd2, 4'd3);
        for (int i = 0; i < 8; i++) send(12'd10, "R8 fresh group after code change");
        idle(3);
        // R8: a partial group dropped when the enable goes low
        for (int i = 0; i < 3; i++) send(12'd3000, "R8 partial dropped");
        set_cfg(1'b0, 3'd2, 4'd3);
        set_cfg(1'b1, 3'd2, 4'd3);
        for (int i = 0; i < 8; i++) send(12'd8, "R8 fresh group after disable");
        idle(3);

        // R9: pass-through, back to back
        set_cfg(1'b0, 3'd5, 4'd4);
        send(12'hABC, "R9 bypass zero-extend");
        send(12'hFFF, "R9 bypass zero-extend");
        send(12'h001, "R9 bypass zero-extend");
        idle(3);

        // R6: the output holds while idle
        idle(6);
        chk(res_data == last_val, "R6 hold while idle", int'(res_data), int'(last_val));
        chk(res_vld == 1'b0, "R6 no strobe while idle", int'(res_vld), 0);

        chk(exp_val_q.size() == 0, "R2 all expected results seen", exp_val_q.size(), 0);
        done = 1'b1;
        report();
        $finish;
    end

endmodule